// File: doc/BRIEF.md
# Page program buffer with wrapping pointer and sequential byte mode

This block sits behind the serial command decoder of a serial flash and handles the data phase of a program command. A frame opens with a start pulse that carries a frame kind and an address. Data bytes then arrive one per strobe and are collected in a 256-entry buffer. A write pointer starts at the low address byte and wraps inside the page. A mark bit records every offset that received data. When the frame closes, the block checks the commit conditions. If they hold, it walks the marked offsets from lowest to highest and issues one array write per clock. Each write merges the new byte into the old contents with a bitwise AND, because programming can only clear bits. The cycle after each write, a second array port reads the location back and compares it with the expected merged value.

A sequential mode programs one byte per frame. The first frame of a sequence supplies an address. Later frames ignore the address and use an internal counter that advances after each commit. The sequence ends by itself after the top address of the array. It also ends when the next address lies in a protected sector, when a write-disable frame arrives, or when a frame aborts. The write-enable latch itself lives outside the block. The block pulses a request to clear it.

The controller has four states. `ST_IDLE` waits for a frame start. It moves to `ST_LOAD` for a program or sequential frame and to `ST_SKIP` for a reserved kind. A write-disable frame leaves it in `ST_IDLE`. `ST_LOAD` collects bytes until the frame ends, then moves to `ST_PROG` when the commit is accepted or back to `ST_IDLE` when it is rejected. `ST_SKIP` discards bytes until the frame ends and then returns to `ST_IDLE`. `ST_PROG` writes one marked offset per cycle and returns to `ST_IDLE` in the first cycle that finds no mark left.

Top module: `ppb_top`

## Requirements
- R1: After reset, `busy`, `seq_active`, `prog_err`, `arr_we` and `wel_clr` are all 0.
- R2: In page mode (`frm_kind`=0), byte n of a frame is placed at in-page offset (start low byte + n) mod 256, inside the page of the start address. Start 0x0FE with three bytes writes 0x0FE, 0x0FF and 0x000 and leaves 0x001–0x0FD unchanged.
- R3: When more than 256 bytes arrive in one page frame, only the final 256 are programmed.
- R4: A commit writes only the marked offsets, once each, in ascending offset order, one write per clock, all inside one page, with `busy` high from the cycle after the frame end until the last write is done.
- R5: Each array write stores the old byte AND the new byte, so bits can only go from 1 to 0 (erased byte = 0xFF).
- R6: A frame end with `frm_whole`=0, with no complete data byte, or with `wel_in`=0 programs nothing and pulses `wel_clr`. A successful page commit also pulses `wel_clr` when it finishes.
- R7: A commit whose start address lies in a sector with its `prot_map` bit set programs nothing and pulses `wel_clr`. Sector s covers the addresses whose bits [ADDR_W-1:SECT_SHIFT] equal s.
- R8: A sequential frame (`frm_kind`=1) outside sequential mode uses `frm_addr`. While `seq_active`=1, a sequential frame ignores `frm_addr` and programs the address after the previous one. Of several bytes in one frame, only the last is programmed.
- R9: After programming the top array address (all ones), sequential mode ends (`seq_active`=0) and `wel_clr` pulses.
- R10: When the address after a sequential write lies in a protected sector, sequential mode ends and `wel_clr` pulses.
- R11: A write-disable frame (`frm_kind`=2) ends sequential mode. A reserved frame (`frm_kind`=3) is ignored: no write, and no change to `seq_active`.
- R12: `prog_err` becomes 1 when a read-back differs from the expected merged value. It stays set until the next page or sequential frame start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_begin | input | 1 | One-cycle frame start pulse |
| frm_kind | input | 2 | Frame kind: 0 page, 1 sequential, 2 write disable, 3 reserved |
| frm_addr | input | ADDR_W | Start address, sampled with `frm_begin` |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| frm_end | input | 1 | Frame end pulse; at least one cycle after the last byte |
| frm_whole | input | 1 | With `frm_end`: address complete and end on a byte boundary |
| wel_in | input | 1 | Write-enable latch state |
| prot_map | input | 2**(ADDR_W-SECT_SHIFT) | Per-sector protect bits, 1 = protected |
| busy | output | 1 | Array writes in progress |
| seq_active | output | 1 | Sequential mode active |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| prog_err | output | 1 | Read-back mismatch seen |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address, also the address of `arr_rdata` |
| arr_wdata | output | 8 | Merged byte to store |
| arr_rdata | input | 8 | Current array byte at `arr_addr` |
| chk_addr | output | ADDR_W | Read-back address |
| chk_rdata | input | 8 | Array byte at `chk_addr` |

## Verification
Properties checked on every clock cycle:
- Array writes occur only while busy.
- Consecutive writes stay in one page and rise in offset.
- An error flag rise is always preceded by a write two cycles earlier.
- A write to the top address is followed by the end of sequential mode.

Only the directed scenarios can show the rest:
- Where the bytes land: the wrap at FFh, the last-256 rule and the AND merge, checked against a bench model of the array.
- Which frames commit and which abort.
- How sequential mode walks its addresses and where it stops.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    typedef enum logic [1:0] {
        K_PAGE  = 2'd0,
        K_SEQ   = 2'd1,
        K_WRDIS = 2'd2,
        K_NONE  = 2'd3
    } frm_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SKIP = 2'd2,
        ST_PROG = 2'd3
    } ppb_state_t;

endpackage

// File: rtl/ppb_page_store.sv
module ppb_page_store #(
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [PAGE_W-1:0]       load_ptr,
    input  logic                    hold,
    input  logic                    wr,
    input  logic [7:0]              din,
    input  logic [PAGE_W-1:0]       rd_idx,
    output logic [7:0]              rd_data,
    input  logic                    drop,
    input  logic [PAGE_W-1:0]       drop_idx,
    output logic [(1<<PAGE_W)-1:0]  marks
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [7:0]        slot [DEPTH];
    logic [PAGE_W-1:0] ptr;

    // data slots carry no reset; the marks say which are valid
    always_ff @(posedge clk) begin
        if (wr) begin
            slot[ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            marks <= '0;
            ptr   <= '0;
        end else if (clr) begin
            marks <= '0;
            ptr   <= load_ptr;
        end else begin
            if (wr) begin
                marks[ptr] <= 1'b1;
                if (!hold) begin
                    ptr <= ptr + 1'b1;   // natural wrap inside the page
                end
            end
            if (drop) begin
                marks[drop_idx] <= 1'b0;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/ppb_first_set.sv
module ppb_first_set #(
    parameter int IW = 8
) (
    input  logic [(1<<IW)-1:0] vec,
    output logic               found,
    output logic [IW-1:0]      idx
);
    localparam int W = 1 << IW;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ppb_readback.sv
module ppb_readback #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fire,
    input  logic [ADDR_W-1:0] fire_addr,
    input  logic [7:0]        fire_val,
    output logic [ADDR_W-1:0] chk_addr,
    input  logic [7:0]        chk_rdata,
    output logic              err
);
    logic              pend;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            addr_q <= '0;
            val_q  <= '0;
            err    <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
            err  <= 1'b0;
        end else begin
            pend <= fire;
            if (fire) begin
                addr_q <= fire_addr;
                val_q  <= fire_val;
            end
            if (pend && (chk_rdata != val_q)) begin
                err <= 1'b1;
            end
        end
    end

    assign chk_addr = addr_q;

endmodule

// File: rtl/ppb_top.sv
module ppb_top #(
    parameter int ADDR_W     = 19,
    parameter int SECT_SHIFT = 16,
    parameter int PAGE_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frm_begin,
    input  logic [1:0]                            frm_kind,
    input  logic [ADDR_W-1:0]                     frm_addr,
    input  logic                                  byte_valid,
    input  logic [7:0]                            byte_data,
    input  logic                                  frm_end,
    input  logic                                  frm_whole,
    input  logic                                  wel_in,
    input  logic [(1<<(ADDR_W-SECT_SHIFT))-1:0]   prot_map,
    output logic                                  busy,
    output logic                                  seq_active,
    output logic                                  wel_clr,
    output logic                                  prog_err,
    output logic                                  arr_we,
    output logic [ADDR_W-1:0]                     arr_addr,
    output logic [7:0]                            arr_wdata,
    input  logic [7:0]                            arr_rdata,
    output logic [ADDR_W-1:0]                     chk_addr,
    input  logic [7:0]                            chk_rdata
);
    import ppb_pkg::*;

    localparam int                DEPTH    = 1 << PAGE_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    ppb_state_t        state, nxt;
    frm_kind_t         kind_in, kind_q;
    logic [ADDR_W-1:0] cur_q, seq_addr, sel_addr, cur_nx;
    logic              seq_on;

    logic              start_prog, st_wr, commit_ok, at_top, nx_prot, seq_stop;
    logic [DEPTH-1:0]  marks;
    logic              found;
    logic [PAGE_W-1:0] idx;
    logic [7:0]        new_byte;

    assign kind_in    = frm_kind_t'(frm_kind);
    assign sel_addr   = (kind_in == K_SEQ && seq_on) ? seq_addr : frm_addr;
    assign start_prog = (state == ST_IDLE) && frm_begin
                        && (kind_in == K_PAGE || kind_in == K_SEQ);
    assign st_wr      = (state == ST_LOAD) && byte_valid;
    assign commit_ok  = frm_whole && (|marks) && wel_in
                        && !prot_map[cur_q[ADDR_W-1:SECT_SHIFT]];
    assign cur_nx     = cur_q + 1'b1;
    assign at_top     = (cur_q == TOP_ADDR);
    assign nx_prot    = prot_map[cur_nx[ADDR_W-1:SECT_SHIFT]];
    assign seq_stop   = at_top || nx_prot;

    ppb_page_store #(.PAGE_W(PAGE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_prog),
        .load_ptr (sel_addr[PAGE_W-1:0]),
        .hold     (kind_q == K_SEQ),
        .wr       (st_wr),
        .din      (byte_data),
        .rd_idx   (idx),
        .rd_data  (new_byte),
        .drop     (arr_we),
        .drop_idx (idx),
        .marks    (marks)
    );

    ppb_first_set #(.IW(PAGE_W)) u_scan (
        .vec   (marks),
        .found (found),
        .idx   (idx)
    );

    ppb_readback #(.ADDR_W(ADDR_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_prog),
        .fire      (arr_we),
        .fire_addr (arr_addr),
        .fire_val  (arr_wdata),
        .chk_addr  (chk_addr),
        .chk_rdata (chk_rdata),
        .err       (prog_err)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (frm_begin) begin
                    if (kind_in == K_PAGE || kind_in == K_SEQ) begin
                        nxt = ST_LOAD;
                    end else if (kind_in == K_NONE) begin
                        nxt = ST_SKIP;
                    end
                end
            end
            ST_LOAD: begin
                if (frm_end) begin
                    nxt = commit_ok ? ST_PROG : ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (frm_end) begin
                    nxt = ST_IDLE;
                end
            end
            ST_PROG: begin
                if (!found) begin
                    nxt = ST_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // frame context and sequential-mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_PAGE;
            cur_q    <= '0;
            seq_on   <= 1'b0;
            seq_addr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frm_begin) begin
                        if (start_prog) begin
                            kind_q <= kind_in;
                            cur_q  <= sel_addr;
                        end
                        if (kind_in == K_PAGE || kind_in == K_WRDIS) begin
                            seq_on <= 1'b0;
                        end
                    end
                end
                ST_LOAD: begin
                    if (frm_end && !commit_ok) begin
                        seq_on <= 1'b0;
                    end
                end
                ST_SKIP: begin
                end
                ST_PROG: begin
                    if (!found && kind_q == K_SEQ) begin
                        seq_on   <= !seq_stop;
                        seq_addr <= cur_nx;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state == ST_PROG);
        arr_we     = (state == ST_PROG) && found;
        arr_addr   = {cur_q[ADDR_W-1:PAGE_W], idx};
        arr_wdata  = new_byte & arr_rdata;
        seq_active = seq_on;
        wel_clr    = ((state == ST_LOAD) && frm_end && !commit_ok)
                  || ((state == ST_PROG) && !found
                      && (kind_q == K_PAGE || seq_stop));
    end

endmodule

// File: rtl/ppb_top_chk.sv
module ppb_top_chk #(
    parameter int ADDR_W = 19,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              prog_err,
    input logic              seq_active
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    AST_WE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);  // R4

    AST_ASCENDING_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            ((arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W]))
             && (arr_addr[PAGE_W-1:0] > $past(arr_addr[PAGE_W-1:0]))));  // R4

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> $past(arr_we, 2));  // R12

    AST_TOP_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arr_we && (arr_addr == TOP_ADDR), 2) |-> !seq_active);  // R9

endmodule

bind ppb_top ppb_top_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .prog_err   (prog_err),
    .seq_active (seq_active)
);

// File: tb/sim_ppb_top.sv
module sim_ppb_top;
    localparam int AW  = 12;
    localparam int SS  = 10;
    localparam int NS  = 1 << (AW - SS);
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_begin = 1'b0;
    logic [1:0]    frm_kind = 2'd0;
    logic [AW-1:0] frm_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = 8'h00;
    logic          frm_end = 1'b0;
    logic          frm_whole = 1'b0;
    logic          wel_in = 1'b1;
    logic [NS-1:0] prot_map = '0;
    logic          busy, seq_active, wel_clr, prog_err, arr_we;
    logic [AW-1:0] arr_addr, chk_addr;
    logic [7:0]    arr_wdata, arr_rdata, chk_rdata;

    logic [7:0]    mem [MEM];
    logic [AW-1:0] fault_addr = '0;
    logic          fault_on = 1'b0;
    int            wcount = 0;
    int            welc = 0;
    logic [AW-1:0] wlog [512];
    int            n_cmp = 0;
    int            n_bad = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ppb_top #(.ADDR_W(AW), .SECT_SHIFT(SS), .PAGE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_begin(frm_begin), .frm_kind(frm_kind),
        .frm_addr(frm_addr), .byte_valid(byte_valid), .byte_data(byte_data),
        .frm_end(frm_end), .frm_whole(frm_whole), .wel_in(wel_in),
        .prot_map(prot_map), .busy(busy), .seq_active(seq_active),
        .wel_clr(wel_clr), .prog_err(prog_err), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .chk_addr(chk_addr), .chk_rdata(chk_rdata)
    );

    // array model: stores what it is given, optional stuck-at-1 bit 0
    assign arr_rdata = mem[arr_addr];
    assign chk_rdata = mem[chk_addr];

    always @(posedge clk) begin
        if (arr_we) begin
            mem[arr_addr] <= (fault_on && arr_addr == fault_addr) ? (arr_wdata | 8'h01) : arr_wdata;
            if (wcount < 512) wlog[wcount] <= arr_addr;
            wcount <= wcount + 1;
        end
        if (wel_clr) welc <= welc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic erase_all();
        for (int i = 0; i < MEM; i++) mem[i] = 8'hFF;
    endtask

    task automatic fbegin(input logic [1:0] k, input logic [AW-1:0] a);
        frm_begin = 1'b1; frm_kind = k; frm_addr = a;
        @(negedge clk);
        frm_begin = 1'b0;
    endtask

    task automatic fbyte(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic fend(input logic whole);
        frm_end = 1'b1; frm_whole = whole;
        @(negedge clk);
        frm_end = 1'b0;
        for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 seq_active", seq_active, 0);
        check("R1 prog_err", prog_err, 0);
        check("R1 arr_we", arr_we, 0);
        check("R1 wel_clr", wel_clr, 0);
    endtask

    task automatic t_wrap();
        int w0, c0;
        erase_all(); w0 = wcount; c0 = welc;
        fbegin(2'd0, 12'h0FE);
        fbyte(8'hA1); fbyte(8'hA2); fbyte(8'hA3);
        fend(1'b1);
        check("R2 off FE", mem[12'h0FE], 8'hA1);
        check("R2 off FF", mem[12'h0FF], 8'hA2);
        check("R2 off 00", mem[12'h000], 8'hA3);
        check("R2 off 01 untouched", mem[12'h001], 8'hFF);
        check("R2 off FD untouched", mem[12'h0FD], 8'hFF);
        check("R4 write count", wcount - w0, 3);
        check("R4 order first", wlog[w0], 12'h000);
        check("R4 order second", wlog[w0+1], 12'h0FE);
        check("R4 order third", wlog[w0+2], 12'h0FF);
        check("R6 wel_clr on page done", welc - c0, 1);
    endtask

    task automatic t_overflow();
        int w0, bad;
        erase_all(); w0 = wcount; bad = 0;
        fbegin(2'd0, 12'h210);
        for (int i = 0; i < 300; i++) fbyte(8'(i) ^ 8'h5A);
        fend(1'b1);
        for (int i = 44; i < 300; i++)
            if (mem[12'h200 + ((12'h10 + i) & 12'hFF)] !== (8'(i) ^ 8'h5A)) bad++;
        check("R3 last 256 kept (mismatching offsets)", bad, 0);
        check("R3 write count", wcount - w0, 256);
    endtask

    task automatic t_and();
        erase_all();
        mem[12'h300] = 8'hF0;
        fbegin(2'd0, 12'h300);
        fbyte(8'h3C);
        fend(1'b1);
        check("R5 AND merge", mem[12'h300], 8'h30);
        check("R5 neighbour untouched", mem[12'h301], 8'hFF);
    endtask

    task automatic t_abort();
        int w0, c0;
        erase_all(); w0 = wcount; c0 = welc;
        fbegin(2'd0, 12'h100); fbyte(8'h12); fend(1'b0);
        check("R6 partial end no write", wcount - w0, 0);
        check("R6 partial end wel_clr", welc - c0, 1);
        fbegin(2'd0, 12'h100); fend(1'b1);
        check("R6 no byte no write", wcount - w0, 0);
        wel_in = 1'b0;
        fbegin(2'd0, 12'h100); fbyte(8'h12); fend(1'b1);
        wel_in = 1'b1;
        check("R6 wel low no write", wcount - w0, 0);
        check("R6 wel_clr per abort", welc - c0, 3);
        check("R6 memory unchanged", mem[12'h100], 8'hFF);
    endtask

    task automatic t_prot();
        int w0, c0;
        erase_all(); w0 = wcount; c0 = welc;
        prot_map = 4'b0010;
        fbegin(2'd0, 12'h450); fbyte(8'h00); fend(1'b1);
        check("R7 protected no write", wcount - w0, 0);
        check("R7 protected wel_clr", welc - c0, 1);
        check("R7 memory unchanged", mem[12'h450], 8'hFF);
        prot_map = '0;
    endtask

    task automatic t_seq();
        int w0;
        erase_all();
        fbegin(2'd1, 12'h120); fbyte(8'h11); fend(1'b1);
        check("R8 first byte", mem[12'h120], 8'h11);
        check("R8 active", seq_active, 1);
        fbegin(2'd1, 12'h999); fbyte(8'h22); fbyte(8'h33); fend(1'b1);
        check("R8 next address, last byte", mem[12'h121], 8'h33);
        check("R8 frm_addr ignored", mem[12'h999], 8'hFF);
        w0 = wcount;
        fbegin(2'd3, 12'h130); fbyte(8'h00); fend(1'b1);
        check("R11 reserved frame no write", wcount - w0, 0);
        check("R11 reserved frame keeps seq", seq_active, 1);
        fbegin(2'd2, 12'h000); @(negedge clk);
        check("R11 write disable exits", seq_active, 0);
    endtask

    task automatic t_top();
        int c0;
        erase_all(); c0 = welc;
        fbegin(2'd1, 12'hFFF); fbyte(8'h42); fend(1'b1);
        check("R9 top byte", mem[12'hFFF], 8'h42);
        check("R9 exit at top", seq_active, 0);
        check("R9 wel_clr at top", welc - c0, 1);
    endtask

    task automatic t_seq_prot();
        int c0;
        erase_all(); prot_map = 4'b0100;
        fbegin(2'd1, 12'h7FE); fbyte(8'h55); fend(1'b1);
        check("R10 still active before boundary", seq_active, 1);
        c0 = welc;
        fbegin(2'd1, 12'h000); fbyte(8'h66); fend(1'b1);
        check("R10 last byte before sector", mem[12'h7FF], 8'h66);
        check("R10 exit at protected sector", seq_active, 0);
        check("R10 wel_clr", welc - c0, 1);
        prot_map = '0;
    endtask

    task automatic t_err();
        erase_all(); fault_addr = 12'h050; fault_on = 1'b1;
        fbegin(2'd0, 12'h050); fbyte(8'h00); fend(1'b1);
        check("R12 error on mismatch", prog_err, 1);
        fault_on = 1'b0;
        fbegin(2'd0, 12'h060);
        check("R12 cleared at frame start", prog_err, 0);
        fbyte(8'h01); fend(1'b1);
        check("R12 no error on good write", prog_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        erase_all();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_wrap();
        t_overflow();
        t_and();
        t_abort();
        t_prot();
        t_seq();
        t_top();
        t_seq_prot();
        t_err();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule